// File: doc/BRIEF.md
# Dead-Time Complementary Output Generator

This block turns a single switching signal per phase into a pair of active-low gate outputs that are never active together. Whenever a phase input changes level, the output that must turn off does so in the very next clock. The output that must turn on waits for a programmable dead time. During that gap both outputs of the pair sit high, which is their inactive level.

Each phase has its own 16-bit down-counter. On every input edge the counter loads from that phase's reload value and then counts down on the clocks where the count-clock enable is high. The same counter serves both edge directions. An edge that arrives while a dead time is still running restarts the count from the reload value, so a pulse narrower than the dead time never reaches either output.

Three identical phases run side by side. Each phase has its own input and reload value, and they share the count-clock enable and the global enable.

Top module: `dtg_top`

## Requirements
- R1: While synchronous reset is high, every output of every pair is high (inactive).
- R2: In steady state with the phase input at 1, the first output of the pair is 0 and the second is 1. With the input at 0, the first output is 1 and the second is 0.
- R3: On a detected input edge with a nonzero reload value, both outputs of that pair are high from the clock edge that captures the input change.
- R4: With the count-clock enable held high, both outputs stay high for exactly the reload value in clocks. After that the delayed output becomes active: the first output after a rising input edge, the second after a falling one.
- R5: The counter advances only on clocks where the count-clock enable is high. Each clock with the enable low lengthens the dead time by one clock.
- R6: An input edge during a running dead time reloads the counter. The gap then lasts the clocks elapsed up to that edge plus the full reload value, and the pair ends at the level of the last edge.
- R7: A reload value of zero gives no dead time. Both outputs switch to their complementary target levels one clock after the edge, with no clock where both are high.
- R8: The phases are independent: simultaneous edges on different phases each get their own phase's dead time.
- R9: While the enable is low, all outputs are high and the counters are cleared. When the enable rises, each pair waits a full dead time before driving its input's level.
- R10: The reload value is taken at the edge. A change to it during a running dead time does not change that dead time.
- R11: The two outputs of a pair are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low forces all outputs inactive |
| cnt_ce | input | 1 | Count-clock enable for the dead-time counters |
| phase_in | input | NPH | One switching input per phase |
| reload_val | input | NPH*CW | Dead time per phase; phase k in bits [k*CW +: CW] |
| out_a_n | output | NPH | First output of each pair, active low, low while the input is 1 |
| out_b_n | output | NPH | Second output of each pair, active low, low while the input is 0 |

## Verification
A counter left one step off shows up at the ports as a gap one clock too long or too short, on the very next edge of that phase. The scoreboard measures every gap on every pair against the expected length. A latched level that goes stale after a restart leaves the pair settled on the wrong output once the gap ends, within reload-value clocks. An enable or arming flag that is not cleared shows up on the first clock after re-enable: an output goes low at once instead of both staying high for the full dead time.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned PH_DEF = 3;
  localparam int unsigned DT_W_DEF = 16;
endpackage

// File: rtl/dtg_edge.sv
module dtg_edge (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic start,
  output logic lvl_now
);
  logic armed_q;
  logic lvl_q;

  // a new window opens on any level change, or on the first enabled clock
  always_comb start = en && (!armed_q || (din != lvl_q));
  always_comb lvl_now = start ? din : lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      armed_q <= en;
      if (start) lvl_q <= din;
    end
  end

  p_level_latch_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (lvl_q == $past(din)));
  p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !armed_q);
endmodule

// File: rtl/dtg_count.sv
module dtg_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start,
  input  logic          ce,
  input  logic [CW-1:0] reload,
  output logic          fire
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] cnt_q;

  always_comb begin
    if (start) fire = (reload == '0);
    else       fire = en && ce && (cnt_q == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)             cnt_q <= '0;
    else if (start)             cnt_q <= reload;
    else if (ce && cnt_q != '0) cnt_q <= cnt_q - ONE;
  end

  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == $past(reload)));
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !start && ce && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !start && !ce) |=> $stable(cnt_q));
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/dtg_drive.sv
module dtg_drive (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic start,
  input  logic fire,
  input  logic lvl_now,
  output logic a_n,
  output logic b_n
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      a_n <= 1'b1;
      b_n <= 1'b1;
    end else if (fire) begin
      a_n <= ~lvl_now;
      b_n <= lvl_now;
    end else if (start) begin
      a_n <= 1'b1;
      b_n <= 1'b1;
    end
  end

  p_never_both_r11: assert property (@(posedge clk) disable iff (rst)
    (a_n || b_n));
  p_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (a_n && b_n));
  p_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !fire) |=> (a_n && b_n));
endmodule

// File: rtl/dtg_phase.sv
module dtg_phase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ce,
  input  logic          din,
  input  logic [CW-1:0] reload,
  output logic          a_n,
  output logic          b_n
);
  logic start;
  logic lvl_now;
  logic fire;

  dtg_edge u_edge (
    .clk(clk), .rst(rst), .en(en), .din(din),
    .start(start), .lvl_now(lvl_now)
  );

  dtg_count #(.CW(CW)) u_count (
    .clk(clk), .rst(rst), .en(en), .start(start), .ce(ce),
    .reload(reload), .fire(fire)
  );

  dtg_drive u_drive (
    .clk(clk), .rst(rst), .en(en), .start(start), .fire(fire),
    .lvl_now(lvl_now), .a_n(a_n), .b_n(b_n)
  );
endmodule

// File: rtl/dtg_top.sv
module dtg_top
  import dtg_pkg::*;
#(
  parameter int unsigned NPH = PH_DEF,
  parameter int unsigned CW  = DT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cnt_ce,
  input  logic [NPH-1:0]    phase_in,
  input  logic [NPH*CW-1:0] reload_val,
  output logic [NPH-1:0]    out_a_n,
  output logic [NPH-1:0]    out_b_n
);
  for (genvar k = 0; k < NPH; k++) begin : g_ph
    dtg_phase #(.CW(CW)) u_ph (
      .clk(clk), .rst(rst), .en(en), .ce(cnt_ce),
      .din(phase_in[k]), .reload(reload_val[k*CW +: CW]),
      .a_n(out_a_n[k]), .b_n(out_b_n[k])
    );
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (&out_a_n && &out_b_n));
endmodule

// File: tb/sim_dtg_top.sv
module sim_dtg_top;
  localparam int NPH = 3;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic cnt_ce = 1'b1;
  logic [NPH-1:0] phase_in = '0;
  logic [NPH*CW-1:0] reload_val = '0;
  logic [NPH-1:0] out_a_n, out_b_n;

  always #5 clk = ~clk;

  dtg_top #(.NPH(NPH), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .en(en), .cnt_ce(cnt_ce), .phase_in(phase_in),
    .reload_val(reload_val), .out_a_n(out_a_n), .out_b_n(out_b_n)
  );

  typedef struct {
    string tag;
    int    len;
    logic  an;
    logic  bn;
  } exp_t;

  exp_t q0[$];
  exp_t q1[$];
  exp_t q2[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(input int ph, input string tag, input int len,
                          input logic an, input logic bn);
    exp_t e;
    e.tag = tag; e.len = len; e.an = an; e.bn = bn;
    case (ph)
      0: q0.push_back(e);
      1: q1.push_back(e);
      default: q2.push_back(e);
    endcase
  endtask

  task automatic set_rl(input int ph, input int val);
    reload_val[ph*CW +: CW] = CW'(val);
  endtask

  task automatic pair_is(input int ph, input logic an, input logic bn, input string tag);
    check(out_a_n[ph] == an && out_b_n[ph] == bn, tag,
          $sformatf("pair %0d {a_n,b_n}", ph),
          {30'd0, out_a_n[ph], out_b_n[ph]}, {30'd0, an, bn});
  endtask

  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: measures every both-inactive gap and compares to the scoreboard
  initial begin
    int run[NPH];
    exp_t e;
    bit have;
    for (int k = 0; k < NPH; k++) run[k] = 0;
    forever begin
      @(posedge clk); #2;
      if (!rst) begin
        for (int k = 0; k < NPH; k++) begin
          check(out_a_n[k] || out_b_n[k], "R11", $sformatf("pair %0d both low", k),
                0, 1);
          if (!en) run[k] = 0;
          else if (out_a_n[k] && out_b_n[k]) run[k]++;
          else begin
            if (run[k] > 0) begin
              have = 1'b1;
              case (k)
                0: if (q0.size() > 0) e = q0.pop_front(); else have = 1'b0;
                1: if (q1.size() > 0) e = q1.pop_front(); else have = 1'b0;
                default: if (q2.size() > 0) e = q2.pop_front(); else have = 1'b0;
              endcase
              if (!have) check(1'b0, "R4", $sformatf("unexpected gap on pair %0d", k),
                               run[k], 0);
              else begin
                check(run[k] == e.len, e.tag, $sformatf("gap length pair %0d", k),
                      run[k], e.len);
                check(out_a_n[k] == e.an && out_b_n[k] == e.bn, e.tag,
                      $sformatf("settled level pair %0d", k),
                      {30'd0, out_a_n[k], out_b_n[k]}, {30'd0, e.an, e.bn});
              end
            end
            run[k] = 0;
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    set_rl(0, 5); set_rl(1, 3); set_rl(2, 8);
    repeat (3) @(posedge clk);
    #2;
    for (int k = 0; k < NPH; k++) pair_is(k, 1'b1, 1'b1, "R1"); // R1 reset state
    @(negedge clk);
    rst = 1'b0;

    // R9: enable start waits a full dead time, settles on input level 0
    push_exp(0, "R9", 5, 1'b1, 1'b0);
    push_exp(1, "R9", 3, 1'b1, 1'b0);
    push_exp(2, "R9", 8, 1'b1, 1'b0);
    @(negedge clk); en = 1'b1;
    after_edge();
    for (int k = 0; k < NPH; k++) pair_is(k, 1'b1, 1'b1, "R9");
    repeat (12) @(negedge clk);
    pair_is(0, 1'b1, 1'b0, "R2"); // R2 input low

    // R3 / R4: rising edge on phase 0
    push_exp(0, "R4", 5, 1'b0, 1'b1);
    phase_in[0] = 1'b1;
    after_edge();
    pair_is(0, 1'b1, 1'b1, "R3");
    repeat (10) @(negedge clk);
    pair_is(0, 1'b0, 1'b1, "R2"); // R2 input high

    // R8: phase 0 falls while phase 1 rises
    push_exp(0, "R8", 5, 1'b1, 1'b0);
    push_exp(1, "R8", 3, 1'b0, 1'b1);
    phase_in[0] = 1'b0; phase_in[1] = 1'b1;
    repeat (12) @(negedge clk);

    // R5: count-clock enable stalled for four clocks inside the window
    push_exp(2, "R5", 12, 1'b0, 1'b1);
    phase_in[2] = 1'b1;
    @(negedge clk); cnt_ce = 1'b0;
    repeat (4) @(negedge clk);
    cnt_ce = 1'b1;
    repeat (16) @(negedge clk);

    // R6: narrow pulse on phase 1 restarts the window
    push_exp(1, "R6", 5, 1'b0, 1'b1);
    phase_in[1] = 1'b0;
    repeat (2) @(negedge clk);
    phase_in[1] = 1'b1;
    repeat (10) @(negedge clk);

    // R10: reload changed mid-window does not alter it
    push_exp(0, "R10", 5, 1'b0, 1'b1);
    phase_in[0] = 1'b1;
    @(negedge clk); set_rl(0, 2);
    repeat (10) @(negedge clk);

    // R7: zero reload switches directly
    set_rl(0, 0);
    @(negedge clk); phase_in[0] = 1'b0;
    after_edge();
    pair_is(0, 1'b1, 1'b0, "R7");
    @(negedge clk); phase_in[0] = 1'b1;
    after_edge();
    pair_is(0, 1'b0, 1'b1, "R7");

    // R9: disable forces all inactive, re-enable restarts the gap
    @(negedge clk); en = 1'b0;
    after_edge();
    for (int k = 0; k < NPH; k++) pair_is(k, 1'b1, 1'b1, "R9");
    repeat (3) @(negedge clk);
    push_exp(1, "R9", 3, 1'b0, 1'b1);
    push_exp(2, "R9", 8, 1'b0, 1'b1);
    en = 1'b1;
    after_edge();
    pair_is(0, 1'b0, 1'b1, "R9"); // zero reload phase drives at once
    pair_is(1, 1'b1, 1'b1, "R9");
    repeat (14) @(negedge clk);

    check(q0.size() + q1.size() + q2.size() == 0, "R4", "unmatched expected gaps",
          q0.size() + q1.size() + q2.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule